// File: doc/BRIEF.md
# Pin Edge Interrupt and Wake Unit

This block watches a bank of general-purpose pins and turns their transitions into interrupt and wake-up requests. Each pin has its own rising-edge enable and falling-edge enable, so it can report rising edges, falling edges or both. A transition on an enabled pin is caught by a capture stage that uses the pin itself as its clock. That stage keeps working while the system clock is stopped. Captured transitions are brought into the system clock domain and set sticky status bits. Rising and falling status are kept apart. Software clears them by writing ones.

The pins are parameterised as two ports, 32 and 14 pins wide by default, and are handled as one flat vector of 46 bits where bit i is pin i. All status bits are ORed into one interrupt line. A per-pin wake vector and a combined wake request are asserted as soon as an enabled transition happens, with no clock edge needed. Registers are reached through a simple single-cycle bus: writes are taken on the clock edge while select and write are high, and read data is combinational.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, both enable registers and both status registers read zero, and `irq` and `wakeReq` are low.
- R2: Address 0 holds the rising-edge enables and address 1 holds the falling-edge enables. Bit i controls pin i, and a written value reads back unchanged.
- R3: A pin change made between clock edges sets its status bit by the third following rising clock edge. A rise on a pin whose rising enable is set sets bit i of the rising status (address 2). A fall on a pin whose falling enable is set sets bit i of the falling status (address 3). A pin with both enables reports each direction in its own register.
- R4: Status bits stay set until a write of 1 to that bit at the status address. Bits written as 0 keep their value.
- R5: If a captured edge on a pin and a clear of that pin's status bit happen in the same clock cycle, the status bit ends up set.
- R6: `irq` is high exactly when at least one bit of either status register is set.
- R7: With the system clock stopped, a transition on an enabled pin raises `wakeOut[i]` and `wakeReq` at once. Once the clock runs again, the status bit is set.
- R8: A transition on a pin whose enable for that direction is clear never sets status and does not raise `wakeOut[i]` or `wakeReq`.
- R9: Address 4 returns the pin levels after a two-flop synchronizer. A write to address 4 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (may be stopped) |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 46 | Pin levels, bit i is pin i |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register address (0..4) |
| busWdata | input | 46 | Write data |
| busRdata | output | 46 | Read data, combinational |
| irq | output | 1 | OR of all status bits |
| wakeOut | output | 46 | Per-pin wake request |
| wakeReq | output | 1 | OR of wakeOut |

## Verification
An edge reaching the status register and a software clear of the same bit can fall in the same cycle. The bench causes this by changing a pin half a cycle before a known edge and then counting the synchronizer stages. It holds a write-one-to-clear to that bit on the bus so that the write is sampled on exactly the edge where the event lands. A read afterwards must show the bit still set. A plain clear then shows that the same write does clear the bit when no edge coincides with it.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_RISE_EN = 3'd0,
    REG_FALL_EN = 3'd1,
    REG_RISE_ST = 3'd2,
    REG_FALL_ST = 3'd3,
    REG_LEVEL   = 3'd4
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    wrRiseEn;
    logic    wrFallEn;
    logic    clrRise;
    logic    clrFall;
    logic    rdValid;
    regSel_e rdSel;
  } ctlStrobe_t;
endpackage

// File: rtl/gpio_edge_capture.sv
// Clock-free edge capture: each pin clocks its own toggle flops.
module gpio_edge_capture #(
  parameter int NUM_PINS = 46
) (
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] riseEn,
  input  logic [NUM_PINS-1:0] fallEn,
  output logic [NUM_PINS-1:0] riseTog,
  output logic [NUM_PINS-1:0] fallTog
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic rTog;
    logic fTog;

    always_ff @(posedge pinIn[i] or negedge rstN) begin
      if (!rstN)          rTog <= 1'b0;
      else if (riseEn[i]) rTog <= ~rTog;
    end

    always_ff @(negedge pinIn[i] or negedge rstN) begin
      if (!rstN)          fTog <= 1'b0;
      else if (fallEn[i]) fTog <= ~fTog;
    end

    assign riseTog[i] = rTog;
    assign fallTog[i] = fTog;
  end
endmodule

// File: rtl/gpio_edge_ctrl.sv
// Bus decode into datapath strobes.
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output ctlStrobe_t        ctl
);
  logic wrAct;
  logic rdAct;

  assign wrAct = busSel & busWr;
  assign rdAct = busSel & ~busWr;

  always_comb begin
    ctl          = '0;
    ctl.rdSel    = regSel_e'(busAddr);
    case (busAddr)
      REG_RISE_EN: ctl.wrRiseEn = wrAct;
      REG_FALL_EN: ctl.wrFallEn = wrAct;
      REG_RISE_ST: ctl.clrRise  = wrAct;
      REG_FALL_ST: ctl.clrFall  = wrAct;
      default:     ;
    endcase
    ctl.rdValid = rdAct && (busAddr <= ADDR_W'(REG_LEVEL));
  end
endmodule

// File: rtl/gpio_edge_datapath.sv
// Synchronizers, event detect, enable and sticky status registers, read mux.
module gpio_edge_datapath
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 46
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          ctl,
  input  logic [NUM_PINS-1:0] busWdata,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] riseTog,
  input  logic [NUM_PINS-1:0] fallTog,
  output logic [NUM_PINS-1:0] riseEn,
  output logic [NUM_PINS-1:0] fallEn,
  output logic [NUM_PINS-1:0] riseStat,
  output logic [NUM_PINS-1:0] fallStat,
  output logic [NUM_PINS-1:0] riseEvt,
  output logic [NUM_PINS-1:0] fallEvt,
  output logic [NUM_PINS-1:0] wakeOut,
  output logic [NUM_PINS-1:0] busRdata
);
  logic [NUM_PINS-1:0] riseS1, riseS2, riseSeen;
  logic [NUM_PINS-1:0] fallS1, fallS2, fallSeen;
  logic [NUM_PINS-1:0] lvlS1, lvlS2;
  logic [NUM_PINS-1:0] clrRiseMask, clrFallMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseS1 <= '0; riseS2 <= '0; riseSeen <= '0;
      fallS1 <= '0; fallS2 <= '0; fallSeen <= '0;
      lvlS1  <= '0; lvlS2  <= '0;
    end else begin
      riseS1 <= riseTog; riseS2 <= riseS1; riseSeen <= riseS2;
      fallS1 <= fallTog; fallS2 <= fallS1; fallSeen <= fallS2;
      lvlS1  <= pinIn;   lvlS2  <= lvlS1;
    end
  end

  assign riseEvt = riseS2 ^ riseSeen;
  assign fallEvt = fallS2 ^ fallSeen;

  assign clrRiseMask = ctl.clrRise ? busWdata : '0;
  assign clrFallMask = ctl.clrFall ? busWdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseEn   <= '0;
      fallEn   <= '0;
      riseStat <= '0;
      fallStat <= '0;
    end else begin
      if (ctl.wrRiseEn) riseEn <= busWdata;
      if (ctl.wrFallEn) fallEn <= busWdata;
      // a new event outranks a clear in the same cycle
      riseStat <= (riseStat & ~clrRiseMask) | riseEvt;
      fallStat <= (fallStat & ~clrFallMask) | fallEvt;
    end
  end

  // pending toggles count before the clock has run
  assign wakeOut = (riseTog ^ riseSeen) | (fallTog ^ fallSeen) | riseStat | fallStat;

  always_comb begin
    busRdata = '0;
    if (ctl.rdValid) begin
      case (ctl.rdSel)
        REG_RISE_EN: busRdata = riseEn;
        REG_FALL_EN: busRdata = fallEn;
        REG_RISE_ST: busRdata = riseStat;
        REG_FALL_ST: busRdata = fallStat;
        REG_LEVEL:   busRdata = lvlS2;
        default:     busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter  int PORT0_PINS = 32,
  parameter  int PORT1_PINS = 14,
  localparam int NUM_PINS   = PORT0_PINS + PORT1_PINS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_PINS-1:0] busWdata,
  output logic [NUM_PINS-1:0] busRdata,
  output logic                irq,
  output logic [NUM_PINS-1:0] wakeOut,
  output logic                wakeReq
);
  ctlStrobe_t          ctl;
  logic [NUM_PINS-1:0] riseEn, fallEn, riseTog, fallTog;
  logic [NUM_PINS-1:0] riseStat, fallStat, riseEvt, fallEvt;

  gpio_edge_ctrl u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .ctl    (ctl)
  );

  gpio_edge_capture #(.NUM_PINS(NUM_PINS)) u_cap (
    .rstN   (rstN),
    .pinIn  (pinIn),
    .riseEn (riseEn),
    .fallEn (fallEn),
    .riseTog(riseTog),
    .fallTog(fallTog)
  );

  gpio_edge_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .busWdata(busWdata),
    .pinIn   (pinIn),
    .riseTog (riseTog),
    .fallTog (fallTog),
    .riseEn  (riseEn),
    .fallEn  (fallEn),
    .riseStat(riseStat),
    .fallStat(fallStat),
    .riseEvt (riseEvt),
    .fallEvt (fallEvt),
    .wakeOut (wakeOut),
    .busRdata(busRdata)
  );

  assign irq     = |(riseStat | fallStat);
  assign wakeReq = |wakeOut;
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int NUM_PINS = 46
) (
  input logic                clk,
  input logic                rstN,
  input logic                busSel,
  input logic                busWr,
  input logic [2:0]          busAddr,
  input logic [NUM_PINS-1:0] busWdata,
  input logic                irq,
  input logic                wakeReq,
  input logic [NUM_PINS-1:0] riseStat,
  input logic [NUM_PINS-1:0] riseEvt,
  input logic [NUM_PINS-1:0] fallEvt
);
  logic [NUM_PINS-1:0] clrR;
  assign clrR = (busSel && busWr && busAddr == 3'd2) ? busWdata : '0;

  // R4: a set rise status bit only drops when cleared
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(riseStat) & ~$past(clrR) & ~riseStat) == '0));

  // R5: an event always leaves its bit set, clear or not
  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|riseEvt) |=> ((riseStat & $past(riseEvt)) == $past(riseEvt)));

  // R6: the interrupt only rises after a captured event
  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past((|riseEvt) || (|fallEvt)));

  // R7: a pending interrupt always keeps a wake request up
  assert_irq_wakes_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> wakeReq);
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWr   (busWr),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .irq     (irq),
  .wakeReq (wakeReq),
  .riseStat(riseStat),
  .riseEvt (riseEvt),
  .fallEvt (fallEvt)
);

// File: tb/test_gpio_edge_irq.sv
`timescale 1ns/1ps
module test_gpio_edge_irq;
  localparam int NP = 46;
  localparam logic [NP-1:0] RISE_EN = 46'h2000_0000_00FF;
  localparam logic [NP-1:0] FALL_EN = 46'h2000_0000_0FF0;
  localparam logic [NP-1:0] ALL1    = '1;
  localparam int NVEC = 5;
  // {pins, clearMask, expRise, expFall}
  localparam logic [4*NP-1:0] VEC [NVEC] = '{
    {46'h3FFF_FFFF_FFFF, ALL1,          46'h2000_0000_00FF, 46'h0},
    {46'h0,              ALL1,          46'h0,              46'h2000_0000_0FF0},
    {46'h0000_0000_0F0F, 46'h0,         46'h0000_0000_000F, 46'h0},
    {46'h0,              ALL1,          46'h0000_0000_000F, 46'h0000_0000_0F00},
    {46'h2000_0000_F0F0, ALL1,          46'h2000_0000_00F0, 46'h0}
  };

  logic          clk = 1'b0;
  logic          clkRun = 1'b1;
  logic          rstN = 1'b0;
  logic [NP-1:0] pinIn = '0;
  logic          busSel = 1'b0;
  logic          busWr = 1'b0;
  logic [2:0]    busAddr = '0;
  logic [NP-1:0] busWdata = '0;
  logic [NP-1:0] busRdata;
  logic          irq;
  logic [NP-1:0] wakeOut;
  logic          wakeReq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 if (clkRun) clk = ~clk;

  gpio_edge_irq i_gpio_edge_irq (
    .clk(clk), .rstN(rstN), .pinIn(pinIn),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .irq(irq), .wakeOut(wakeOut), .wakeReq(wakeReq)
  );

  task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [NP-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [NP-1:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 irq", NP'(irq), '0);
    check("R1 wakeReq", NP'(wakeReq), '0);
    for (int a = 0; a < 4; a++) begin
      busRead(3'(a), rd);
      check("R1 register", rd, '0);
    end

    // R2 enables
    busWrite(3'd0, RISE_EN);
    busWrite(3'd1, FALL_EN);
    busRead(3'd0, rd); check("R2 rise enable", rd, RISE_EN);
    busRead(3'd1, rd); check("R2 fall enable", rd, FALL_EN);

    // R3 / R8 vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [NP-1:0] vp, vc, vr, vf;
      {vp, vc, vr, vf} = VEC[v];
      @(negedge clk);
      pinIn = vp;
      repeat (3) @(negedge clk);
      busRead(3'd2, rd); check("R3 R8 rise status", rd, vr);
      busRead(3'd3, rd); check("R3 R8 fall status", rd, vf);
      busWrite(3'd2, vc);
      busWrite(3'd3, vc);
    end

    // R9 level readback, writes at address 4 ignored
    busRead(3'd4, rd); check("R9 level", rd, 46'h2000_0000_F0F0);
    busWrite(3'd4, ALL1);
    busRead(3'd0, rd); check("R9 write ignored", rd, RISE_EN);
    check("R6 irq idle", NP'(irq), '0);

    // R4 partial clear, R6 irq
    @(negedge clk); pinIn = '0;
    repeat (3) @(negedge clk);
    #1 check("R6 irq set", NP'(irq), 46'h1);
    busWrite(3'd3, 46'h30);
    busRead(3'd3, rd); check("R4 partial clear", rd, 46'h2000_0000_00C0);
    busWrite(3'd3, ALL1);
    #1 check("R6 irq cleared", NP'(irq), '0);

    // R5 event and clear in the same cycle
    @(negedge clk); pinIn[0] = 1'b1;
    repeat (3) @(negedge clk);
    pinIn[0] = 1'b0;
    repeat (4) @(negedge clk);
    busRead(3'd2, rd); check("R5 setup", rd, 46'h1);
    @(negedge clk); pinIn[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = 3'd2; busWdata = 46'h1;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
    busRead(3'd2, rd); check("R5 event beats clear", rd, 46'h1);
    busWrite(3'd2, 46'h1);
    busRead(3'd2, rd); check("R4 plain clear", rd, '0);

    // R7 wake with the clock stopped
    @(negedge clk);
    clkRun = 1'b0;
    #10;
    check("R7 wake idle", NP'(wakeReq), '0);
    pinIn[1] = 1'b1;
    #1;
    check("R7 wakeReq", NP'(wakeReq), 46'h1);
    check("R7 wakeOut", wakeOut, 46'h2);
    check("R7 no irq while stopped", NP'(irq), '0);
    #10 clkRun = 1'b1;
    repeat (4) @(negedge clk);
    busRead(3'd2, rd); check("R7 status after restart", rd, 46'h2);
    busWrite(3'd2, ALL1);

    // R8 disabled pin raises no wake
    @(negedge clk); pinIn[20] = 1'b1;
    #1;
    check("R8 wakeOut", wakeOut, '0);
    check("R8 wakeReq", NP'(wakeReq), '0);
    repeat (4) @(negedge clk);
    busRead(3'd2, rd); check("R8 rise status", rd, '0);
    busRead(3'd3, rd); check("R8 fall status", rd, '0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule